// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the addresses of a four-beat burst access to a synchronous memory. A burst is opened by one of two start strobes: one driven from the processor side, the other from the memory controller side. Either strobe copies the external address into the block. After that the block walks the two low address bits through the four beats of the aligned block, one step for each rising edge on which the advance input is high.

A mode input chooses the beat order. In interleaved order each beat's low bits are the start bits exclusive-ORed with the beat number. In linear order the low bits count upward from the start bits and wrap within the block. The upper address bits never change during a burst. The block drives the current full address and a flag that stays high while a burst is open.

The asynchronous active-low reset is brought into the clock domain through a two-stage synchronizer. Reset is applied at once and released on a clock edge.

Top module: `bas_burst_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `busy_o` is 0 and `addr_o` is all zeros.
- R2: If either `cpu_strb_i` or `ctl_strb_i` is high at a rising edge, then after that edge `addr_o` equals the `addr_i` sampled at that edge and `busy_o` is 1.
- R3: When the order latched at the strobe is interleaved (`lin_mode_i`=0), the low two bits of `addr_o` at beat n (n = 0..3) are the start low bits XOR n. For example, a start of 1 gives 1,0,3,2.
- R4: When the order latched at the strobe is linear (`lin_mode_i`=1), the low two bits of `addr_o` at beat n are (start low bits + n) mod 4. For example, a start of 1 gives 1,2,3,0.
- R5: `lin_mode_i` is sampled only at a strobe edge. Changing it during a burst does not alter the sequence.
- R6: During a burst the bits of `addr_o` above bit 1 keep their captured value. The low bits wrap with no carry into the upper bits.
- R7: While `busy_o` is 1, each edge with `adv_i` high and no strobe advances one beat. Advancing from beat 3 returns `addr_o` to the start address and clears `busy_o`.
- R8: An edge with no strobe and `adv_i` low leaves `addr_o` and `busy_o` unchanged.
- R9: `adv_i` has no effect while `busy_o` is 0: `addr_o` and `busy_o` hold.
- R10: When a strobe and `adv_i` are high at the same edge, the strobe wins. `addr_o` becomes the new `addr_i` at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strb_i | input | 1 | Processor-side burst start strobe |
| ctl_strb_i | input | 1 | Controller-side burst start strobe |
| adv_i | input | 1 | Advance to next beat |
| lin_mode_i | input | 1 | Beat order: 1 linear, 0 interleaved |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |
| busy_o | output | 1 | Burst open flag |

## Verification
A corrupted beat count appears on `addr_o` in the cycle right after the edge that stored it. The low two bits then leave the expected order, and in interleaved order a wrong count shows up as the wrong bit flipping. A lost or stuck open flag shows up later: either an advance issued while idle moves the address, or a burst fails to close after its fourth beat. Reference sequences from the bench are compared on every cycle, so each such error is seen within one edge of the cycle where it becomes visible.

// File: rtl/bas_pkg.sv
package bas_pkg;
  parameter int unsigned BEAT_W = 2;
  localparam int unsigned BEATS = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_LIN = 1'b1
  } order_e;
endpackage

// File: rtl/bas_rst_sync.sv
module bas_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bas_start_capture.sv
module bas_start_capture
  import bas_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lin_mode_i,
  output logic [ADDR_W-1:0] base_o,
  output order_e            order_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  order_e            order_q, order_d;

  always_comb begin
    base_d  = base_q;
    order_d = order_q;
    if (load_en) begin
      base_d  = addr_i;
      order_d = lin_mode_i ? ORD_LIN : ORD_XOR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_XOR;
    end else begin
      base_q  <= base_d;
      order_q <= order_d;
    end
  end

  assign base_o  = base_q;
  assign order_o = order_q;

  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> order_q == $past(order_q)); // R5
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  logic  adv_i,
  output beat_t beat_o,
  output logic  active_o
);
  beat_t beat_q, beat_d;
  logic  active_q, active_d;
  logic  step_en;
  logic  last_beat;

  assign last_beat = &beat_q;
  assign step_en   = active_q && adv_i && !load_en;

  always_comb begin
    beat_d   = beat_q;
    active_d = active_q;
    if (load_en) begin
      beat_d   = '0;
      active_d = 1'b1;
    end else if (step_en) begin
      beat_d   = beat_q + beat_t'(1);
      active_d = !last_beat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      active_q <= 1'b0;
    end else begin
      beat_q   <= beat_d;
      active_q <= active_d;
    end
  end

  assign beat_o   = beat_q;
  assign active_o = active_q;

  AST_STRB_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (beat_q == '0) && active_q); // R10
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && adv_i && !load_en) |=> beat_q == beat_t'($past(beat_q) + beat_t'(1))); // R7
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && adv_i && !load_en && (&beat_q)) |=> !active_q); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !load_en) |=> $stable(beat_q) && !active_q); // R9
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] base_i,
  input  beat_t             beat_i,
  input  order_e            order_i,
  output logic [ADDR_W-1:0] addr_o
);
  beat_t start_lo;
  beat_t lo_xor, lo_lin, lo_sel;

  assign start_lo = base_i[BEAT_W-1:0];
  assign lo_xor   = start_lo ^ beat_i;
  assign lo_lin   = start_lo + beat_i;
  assign lo_sel   = (order_i == ORD_LIN) ? lo_lin : lo_xor;

  generate
    if (ADDR_W > BEAT_W) begin : g_upper
      assign addr_o = {base_i[ADDR_W-1:BEAT_W], lo_sel};
    end else begin : g_low_only
      assign addr_o = lo_sel[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/bas_burst_seq.sv
module bas_burst_seq
  import bas_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strb_i,
  input  logic              ctl_strb_i,
  input  logic              adv_i,
  input  logic              lin_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o
);
  logic              rst_sync_n;
  logic              load_en;
  logic [ADDR_W-1:0] base;
  order_e            order;
  beat_t             beat;

  assign load_en = cpu_strb_i || ctl_strb_i;

  bas_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bas_start_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_en    (load_en),
    .addr_i     (addr_i),
    .lin_mode_i (lin_mode_i),
    .base_o     (base),
    .order_o    (order)
  );

  bas_beat_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (load_en),
    .adv_i    (adv_i),
    .beat_o   (beat),
    .active_o (busy_o)
  );

  bas_order_map #(.ADDR_W(ADDR_W)) u_map (
    .base_i  (base),
    .beat_i  (beat),
    .order_i (order),
    .addr_o  (addr_o)
  );

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_en |=> (addr_o == $past(addr_i)) && busy_o); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en && busy_o) |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en && !adv_i) |=> $stable(addr_o) && $stable(busy_o)); // R8
  AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en && !busy_o) |=> $stable(addr_o) && !busy_o); // R9
endmodule

// File: tb/bas_burst_seq_tb.sv
module bas_burst_seq_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_strb, ctl_strb, adv, lin;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          busy;

  int n_cmp = 0;
  int n_bad = 0;

  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;
  logic          m_act;
  logic          m_lin;

  always #2 clk = ~clk;

  bas_burst_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_strb_i(cpu_strb), .ctl_strb_i(ctl_strb),
    .adv_i(adv), .lin_mode_i(lin), .addr_i(addr_in), .addr_o(addr_out), .busy_o(busy)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] n, logic l);
    logic [1:0] lo;
    lo = l ? 2'(b[1:0] + n) : (b[1:0] ^ n);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic c, logic k, logic a, logic l, logic [AW-1:0] ad);
    string tag;
    logic  was_act;
    @(negedge clk);
    cpu_strb = c; ctl_strb = k; adv = a; lin = l; addr_in = ad;
    was_act = m_act;
    if (c || k) begin
      m_base = ad; m_beat = 2'd0; m_act = 1'b1; m_lin = l;
      tag = a ? "R10" : "R2";
    end else if (a && m_act) begin
      if (m_beat == 2'd3) m_act = 1'b0;
      m_beat = m_beat + 2'd1;
      tag = m_lin ? "R4/R7" : "R3/R7";
    end else if (a) begin
      tag = "R9";
    end else begin
      tag = "R8";
    end
    @(posedge clk);
    #1;
    check(tag, addr_out, exp_addr(m_base, m_beat, m_lin));
    check({tag, " busy"}, AW'(busy), AW'(m_act));
    if (was_act && !(c || k))
      check("R6 upper", AW'(addr_out[AW-1:2]), AW'(m_base[AW-1:2]));
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [1:0] seq [4];
    seed = 32'd1234;
    void'($urandom(seed));
    m_base = '0; m_beat = '0; m_act = 1'b0; m_lin = 1'b0;
    cpu_strb = 0; ctl_strb = 0; adv = 0; lin = 0; addr_in = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset addr", addr_out, '0);
    check("R1 reset busy", AW'(busy), '0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after release", addr_out, '0);

    // R9: advance while idle
    step(0, 0, 1, 0, 18'h3ffff);

    // R3: interleaved, start 1 -> 1,0,3,2
    seq = '{2'd1, 2'd0, 2'd3, 2'd2};
    step(1, 0, 0, 0, 18'h2a5);
    check("R3 beat0", AW'(addr_out[1:0]), AW'(seq[0]));
    for (int i = 1; i < 4; i++) begin
      step(0, 0, 1, 1, 18'h0); // lin toggled mid-burst: R5
      check("R3/R5 order", AW'(addr_out[1:0]), AW'(seq[i]));
    end
    step(0, 0, 1, 0, 18'h0);
    check("R7 end busy", AW'(busy), '0);
    check("R7 end addr", addr_out, 18'h2a5);

    // R4: linear, start 1 -> 1,2,3,0 with upper bits all ones (R6 no carry)
    seq = '{2'd1, 2'd2, 2'd3, 2'd0};
    step(0, 1, 0, 1, 18'h3fffd);
    for (int i = 1; i < 4; i++) begin
      step(0, 0, 1, 0, 18'h0);
      check("R4/R5 order", AW'(addr_out[1:0]), AW'(seq[i]));
      check("R6 no carry", AW'(addr_out[AW-1:2]), AW'(18'h3fffd >> 2));
    end

    // R10: strobe with advance mid-burst
    step(1, 0, 0, 0, 18'h100);
    step(0, 0, 1, 0, 18'h0);
    step(1, 1, 1, 1, 18'h0aa);
    check("R10 beat0", addr_out, 18'h0aa);
    step(0, 0, 0, 0, 18'h155); // R8 hold
    check("R8 hold", addr_out, 18'h0aa);

    for (int i = 0; i < 3000; i++) begin
      logic c, k, a, l;
      c = ($urandom % 8) == 0;
      k = ($urandom % 10) == 0;
      a = ($urandom % 3) != 0;
      l = 1'($urandom);
      step(c, k, a, l, AW'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule